// File: doc/BRIEF.md
# Cache Power-Down and Wakeup Sequencer

This block steps a cache through an orderly sleep and wake cycle. A sleep command starts a flush of the cache. Once the cache reports that the flush is finished, the sequencer gates the cache logic domain and waits for the power switch to acknowledge. If SRAM gating is enabled, it then removes the SRAM supply. A wake command reverses the sequence: the SRAM supply comes back first, then the logic power-down is released. The block waits for the acknowledge to fall, counts a settle period, optionally pulses a cache reset, and then returns to idle.

The cache and the power switches sit outside the block and are seen only through their handshake lines. Every wait on an external handshake has a timeout. When a timeout expires, the block releases its outputs, raises a sticky error flag and goes back to idle. The current phase is always visible as a 4-bit code.

Top module: `cache_pwr_seq`

## Requirements
- R1: A sleep command seen in IDLE moves the block to FLUSH on the next clock edge. `flush_req_o` stays high for as long as the block is in FLUSH and drops on the edge where `flush_ok_i` is sampled high.
- R2: Logic power-down (`logic_pd_o`) rises only on the edge that follows a sampled `flush_ok_i`. It is never high at the same time as `flush_req_o`.
- R3: The SRAM gating enable and the reset-on-wake enable are sampled when a sleep command is accepted. When SRAM gating was sampled as enabled, `sram_gate_o` rises one edge after `pd_ack_i` is sampled high in GATE_LOGIC, with a single GATE_SRAM cycle before OFF. It is high only while `logic_pd_o` is high. When SRAM gating was sampled as disabled, `sram_gate_o` stays low.
- R4: A sleep command is ignored in every phase except IDLE. A wake command is ignored in every phase except OFF.
- R5: A wake command in OFF moves the block to UNGATE. If the SRAM was gated, `sram_gate_o` falls one cycle before `logic_pd_o`. If it was not gated, `logic_pd_o` falls on entry to UNGATE.
- R6: After `pd_ack_i` is sampled low in UNGATE, the block stays in SETTLE for exactly SETTLE_CYC cycles (default 64).
- R7: If reset-on-wake was sampled as enabled, `cache_rst_n_o` is held low for exactly RST_CYC cycles in RESET. RST_CYC has a default of 2 and is never less than 2. READY then lasts one cycle, after which the block returns to IDLE.
- R8: Any of FLUSH, GATE_LOGIC or UNGATE that is not left within TIMEOUT_CYC cycles returns the block to IDLE. All outputs are released and `timeout_o` is set. `timeout_o` clears when the next sleep command is accepted.
- R9: `phase_o` encodes the phase as follows: IDLE=0, FLUSH=1, GATE_LOGIC=2, GATE_SRAM=3, OFF=4, UNGATE=5, SETTLE=6, RESET=7, READY=8.
- R10: During and after reset, the block is in IDLE with `flush_req_o`, `logic_pd_o`, `sram_gate_o` and `timeout_o` low and `cache_rst_n_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sleep_cmd_i | input | 1 | Sleep command pulse |
| wake_cmd_i | input | 1 | Wake command pulse |
| sram_gate_en_i | input | 1 | Gate the SRAM supply during this sleep |
| reset_on_wake_i | input | 1 | Pulse the cache reset during the next wakeup |
| flush_ok_i | input | 1 | Cache reports that all dirty lines are written back |
| pd_ack_i | input | 1 | Power switch acknowledge for the logic domain |
| flush_req_o | output | 1 | Flush request to the cache |
| logic_pd_o | output | 1 | Logic domain power-down |
| sram_gate_o | output | 1 | SRAM supply shutdown |
| cache_rst_n_o | output | 1 | Active-low reset to the cache |
| phase_o | output | 4 | Current phase code |
| timeout_o | output | 1 | Sticky handshake timeout flag |

## Verification
Every output is decoded from registered state, so each result is due on the first clock edge after the stimulus that causes it. The one exception is the wake path with SRAM gating, where `logic_pd_o` falls one edge after `sram_gate_o`. The bench drives inputs on the falling clock edge and samples outputs on the next falling edge, so exactly one rising edge lies between a stimulus and its check. SETTLE, RESET and the timeout windows are measured by counting the falling edges on which that phase is observed. That count is compared with the parameter value. The sweep covers both configuration enables, several flush and acknowledge delays, and each timeout path.

// File: rtl/cache_pwr_pkg.sv
package cache_pwr_pkg;

  // Phase codes; values are visible on phase_o (R9)
  typedef enum logic [3:0] {
    PH_IDLE       = 4'd0,
    PH_FLUSH      = 4'd1,
    PH_GATE_LOGIC = 4'd2,
    PH_GATE_SRAM  = 4'd3,
    PH_OFF        = 4'd4,
    PH_UNGATE     = 4'd5,
    PH_SETTLE     = 4'd6,
    PH_RESET      = 4'd7,
    PH_READY      = 4'd8
  } pwr_phase_e;

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Saturating up-counter, cleared on every phase change
  always_comb begin
    cnt_en = restart || (cnt_q != {CNT_W{1'b1}});
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import cache_pwr_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1024,
  parameter int SETTLE_CYC  = 64,
  parameter int RST_CYC     = 2,
  parameter int CNT_W       = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_cmd,
  input  logic             wake_cmd,
  input  logic             sram_en,
  input  logic             rst_en,
  input  logic             flush_ok,
  input  logic             pd_ack,
  input  logic [CNT_W-1:0] cnt,
  output pwr_phase_e       state_o,
  output logic             sram_sel_o,
  output logic             hold_o,
  output logic             tmo_o,
  output logic             restart_o
);

  localparam logic [CNT_W-1:0] TMO_LAST    = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] RST_LAST    = CNT_W'(RST_CYC - 1);

  pwr_phase_e state_q, state_d;
  logic       sram_sel_q, sram_sel_d;
  logic       rst_sel_q, rst_sel_d;
  logic       hold_q, hold_d;
  logic       tmo_q, tmo_d;
  logic       tmo_hit;
  logic       state_en, cfg_en;

  assign tmo_hit = (cnt == TMO_LAST);

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    sram_sel_d = sram_sel_q;
    rst_sel_d  = rst_sel_q;
    tmo_d      = tmo_q;
    hold_d     = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (sleep_cmd) begin
          state_d    = PH_FLUSH;
          tmo_d      = 1'b0;
          sram_sel_d = sram_en;
          rst_sel_d  = rst_en;
        end
      end
      PH_FLUSH: begin
        if (flush_ok) begin
          state_d = PH_GATE_LOGIC;
        end else if (tmo_hit) begin
          state_d = PH_IDLE;
          tmo_d   = 1'b1;
        end
      end
      PH_GATE_LOGIC: begin
        if (pd_ack) begin
          state_d = sram_sel_q ? PH_GATE_SRAM : PH_OFF;
        end else if (tmo_hit) begin
          state_d = PH_IDLE;
          tmo_d   = 1'b1;
        end
      end
      PH_GATE_SRAM: state_d = PH_OFF;
      PH_OFF: begin
        if (wake_cmd) begin
          state_d = PH_UNGATE;
          hold_d  = sram_sel_q;
        end
      end
      PH_UNGATE: begin
        if (hold_q) begin
          state_d = PH_UNGATE;
        end else if (!pd_ack) begin
          state_d = PH_SETTLE;
        end else if (tmo_hit) begin
          state_d = PH_IDLE;
          tmo_d   = 1'b1;
        end
      end
      PH_SETTLE: begin
        if (cnt == SETTLE_LAST) begin
          state_d = rst_sel_q ? PH_RESET : PH_READY;
        end
      end
      PH_RESET: begin
        if (cnt == RST_LAST) begin
          state_d = PH_READY;
        end
      end
      PH_READY: state_d = PH_IDLE;
      default:  state_d = PH_IDLE;
    endcase
  end

  assign state_en  = (state_d != state_q);
  assign cfg_en    = (state_q == PH_IDLE) && sleep_cmd;
  assign restart_o = state_en || hold_q;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_sel_q <= 1'b0;
      rst_sel_q  <= 1'b0;
    end else if (cfg_en) begin
      sram_sel_q <= sram_sel_d;
      rst_sel_q  <= rst_sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      tmo_q  <= tmo_d;
    end
  end

  assign state_o    = state_q;
  assign sram_sel_o = sram_sel_q;
  assign hold_o     = hold_q;
  assign tmo_o      = tmo_q;

endmodule

// File: rtl/pwr_seq_outdec.sv
module pwr_seq_outdec
  import cache_pwr_pkg::*;
(
  input  pwr_phase_e  state,
  input  logic        sram_sel,
  input  logic        hold,
  output logic        flush_req,
  output logic        logic_pd,
  output logic        sram_gate,
  output logic        cache_rst_n,
  output logic [3:0]  phase
);

  always_comb begin
    flush_req   = (state == PH_FLUSH);
    logic_pd    = (state == PH_GATE_LOGIC) || (state == PH_GATE_SRAM) ||
                  (state == PH_OFF) || ((state == PH_UNGATE) && hold);
    sram_gate   = sram_sel && ((state == PH_GATE_SRAM) || (state == PH_OFF));
    cache_rst_n = (state != PH_RESET);
    phase       = state;
  end

endmodule

// File: rtl/cache_pwr_seq.sv
module cache_pwr_seq
  import cache_pwr_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1024,
  parameter int SETTLE_CYC  = 64,
  parameter int RST_CYC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_cmd_i,
  input  logic       wake_cmd_i,
  input  logic       sram_gate_en_i,
  input  logic       reset_on_wake_i,
  input  logic       flush_ok_i,
  input  logic       pd_ack_i,
  output logic       flush_req_o,
  output logic       logic_pd_o,
  output logic       sram_gate_o,
  output logic       cache_rst_n_o,
  output logic [3:0] phase_o,
  output logic       timeout_o
);

  // Effective counts: reset pulse never shorter than two cycles
  localparam int TMO_EFF    = (TIMEOUT_CYC < 1) ? 1 : TIMEOUT_CYC;
  localparam int SETTLE_EFF = (SETTLE_CYC < 1) ? 1 : SETTLE_CYC;
  localparam int RST_EFF    = (RST_CYC < 2) ? 2 : RST_CYC;
  localparam int MAX_A      = (TMO_EFF > SETTLE_EFF) ? TMO_EFF : SETTLE_EFF;
  localparam int MAX_CNT    = (MAX_A > RST_EFF) ? MAX_A : RST_EFF;
  localparam int CNT_W      = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0] cnt;
  logic             restart;
  pwr_phase_e       state;
  logic             sram_sel;
  logic             hold;

  pwr_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .cnt_o   (cnt)
  );

  pwr_seq_fsm #(
    .TIMEOUT_CYC (TMO_EFF),
    .SETTLE_CYC  (SETTLE_EFF),
    .RST_CYC     (RST_EFF),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_cmd  (sleep_cmd_i),
    .wake_cmd   (wake_cmd_i),
    .sram_en    (sram_gate_en_i),
    .rst_en     (reset_on_wake_i),
    .flush_ok   (flush_ok_i),
    .pd_ack     (pd_ack_i),
    .cnt        (cnt),
    .state_o    (state),
    .sram_sel_o (sram_sel),
    .hold_o     (hold),
    .tmo_o      (timeout_o),
    .restart_o  (restart)
  );

  pwr_seq_outdec u_dec (
    .state       (state),
    .sram_sel    (sram_sel),
    .hold        (hold),
    .flush_req   (flush_req_o),
    .logic_pd    (logic_pd_o),
    .sram_gate   (sram_gate_o),
    .cache_rst_n (cache_rst_n_o),
    .phase       (phase_o)
  );

endmodule

// File: rtl/cache_pwr_seq_chk.sv
module cache_pwr_seq_chk
  import cache_pwr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       flush_ok_i,
  input logic       pd_ack_i,
  input logic       flush_req_o,
  input logic       logic_pd_o,
  input logic       sram_gate_o,
  input logic       cache_rst_n_o,
  input logic [3:0] phase_o
);

  // R2
  pd_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(logic_pd_o) |-> $past(flush_ok_i));

  // R2
  flush_pd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req_o |-> !logic_pd_o);

  // R3
  sram_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_gate_o) |-> ($past(pd_ack_i) && logic_pd_o));

  // R3
  sram_inside_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_gate_o |-> logic_pd_o);

  // R5
  sram_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_gate_o) |-> logic_pd_o);

  // R5
  pd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(logic_pd_o) |-> !sram_gate_o);

  // R7
  rst_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cache_rst_n_o |-> (!logic_pd_o && !sram_gate_o && !flush_req_o));

  // R7
  ready_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 4'(PH_READY)) |=> (phase_o == 4'(PH_IDLE)));

endmodule

bind cache_pwr_seq cache_pwr_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush_ok_i    (flush_ok_i),
  .pd_ack_i      (pd_ack_i),
  .flush_req_o   (flush_req_o),
  .logic_pd_o    (logic_pd_o),
  .sram_gate_o   (sram_gate_o),
  .cache_rst_n_o (cache_rst_n_o),
  .phase_o       (phase_o)
);

// File: tb/cache_pwr_seq_test.sv
module cache_pwr_seq_test;
  import cache_pwr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 12;
  localparam int SETTLE     = 64;
  localparam int RSTC       = 2;
  localparam int WDOG       = 150000;

  logic clk, rst_n;
  logic sleep_cmd, wake_cmd, sram_en, rst_en, flush_ok, pd_ack;
  logic flush_req, logic_pd, sram_gate, cache_rst_n, timeout;
  logic [3:0] phase;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  cache_pwr_seq #(.TIMEOUT_CYC(TMO), .SETTLE_CYC(SETTLE), .RST_CYC(RSTC)) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .sleep_cmd_i     (sleep_cmd),
    .wake_cmd_i      (wake_cmd),
    .sram_gate_en_i  (sram_en),
    .reset_on_wake_i (rst_en),
    .flush_ok_i      (flush_ok),
    .pd_ack_i        (pd_ack),
    .flush_req_o     (flush_req),
    .logic_pd_o      (logic_pd),
    .sram_gate_o     (sram_gate),
    .cache_rst_n_o   (cache_rst_n),
    .phase_o         (phase),
    .timeout_o       (timeout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_sleep(input bit s, input bit r);
    sram_en = s; rst_en = r; sleep_cmd = 1'b1;
    tick();
    sleep_cmd = 1'b0;
    // flip the enables: the sampled values must be kept (R3)
    sram_en = ~s; rst_en = ~r;
  endtask

  task automatic to_off(input bit s, input bit r, input int fd, input int ad);
    // R4: wake in IDLE ignored
    wake_cmd = 1'b1; tick(); wake_cmd = 1'b0;
    check("R4 idle wake", int'(phase), int'(PH_IDLE));
    pulse_sleep(s, r);
    check("R1 phase", int'(phase), int'(PH_FLUSH));
    check("R1 flush_req", int'(flush_req), 1);
    check("R8 timeout cleared", int'(timeout), 0);
    for (int i = 0; i < fd; i++) begin
      wake_cmd = (i == 0);
      tick();
      wake_cmd = 1'b0;
      check("R4 flush hold", int'(phase), int'(PH_FLUSH));
      check("R1 flush_req held", int'(flush_req), 1);
    end
    flush_ok = 1'b1; tick(); flush_ok = 1'b0;
    check("R2 phase", int'(phase), int'(PH_GATE_LOGIC));
    check("R1 flush_req drop", int'(flush_req), 0);
    check("R2 logic_pd", int'(logic_pd), 1);
    check("R3 no early sram", int'(sram_gate), 0);
    for (int i = 0; i < ad; i++) begin
      tick();
      check("R3 waiting ack", int'(sram_gate), 0);
    end
    pd_ack = 1'b1; tick();
    if (s) begin
      check("R3 gate sram phase", int'(phase), int'(PH_GATE_SRAM));
      check("R3 sram on", int'(sram_gate), 1);
      tick();
    end
    check("R3 off phase", int'(phase), int'(PH_OFF));
    check("R3 sram level", int'(sram_gate), int'(s));
    check("R2 pd in off", int'(logic_pd), 1);
    // R4: sleep in OFF ignored
    sleep_cmd = 1'b1; tick(); sleep_cmd = 1'b0;
    check("R4 off sleep", int'(phase), int'(PH_OFF));
    check("R4 off pd kept", int'(logic_pd), 1);
  endtask

  task automatic from_off(input bit s, input bit r, input int ad);
    int n;
    wake_cmd = 1'b1; tick(); wake_cmd = 1'b0;
    check("R5 ungate phase", int'(phase), int'(PH_UNGATE));
    check("R5 sram released", int'(sram_gate), 0);
    if (s) begin
      check("R5 pd still on", int'(logic_pd), 1);
      tick();
    end
    check("R5 pd released", int'(logic_pd), 0);
    for (int i = 0; i < ad; i++) begin
      tick();
      check("R5 waiting ack drop", int'(phase), int'(PH_UNGATE));
    end
    pd_ack = 1'b0; tick();
    n = 0;
    while (phase == 4'(PH_SETTLE) && n < 1000) begin
      n++; tick();
    end
    check("R6 settle length", n, SETTLE);
    if (r) begin
      n = 0;
      while (phase == 4'(PH_RESET) && n < 100) begin
        check("R7 reset low", int'(cache_rst_n), 0);
        n++; tick();
      end
      check("R7 reset length", n, RSTC);
    end
    check("R7 ready", int'(phase), int'(PH_READY));
    check("R7 rst high", int'(cache_rst_n), 1);
    tick();
    check("R7 back idle", int'(phase), int'(PH_IDLE));
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    sleep_cmd = 0; wake_cmd = 0; sram_en = 0; rst_en = 0; flush_ok = 0; pd_ack = 0;
    tick(); tick();
    check("R10 reset phase", int'(phase), int'(PH_IDLE));
    check("R10 reset outs", int'({flush_req, logic_pd, sram_gate, timeout}), 0);
    check("R10 reset rst_n", int'(cache_rst_n), 1);
    rst_n = 1'b1;
    tick();
    check("R10 after reset", int'(phase), int'(PH_IDLE));

    // Sweep of configuration and handshake delays
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < 2; r++)
        for (int fd = 0; fd < 3; fd++)
          for (int ad = 0; ad < 3; ad++) begin
            to_off(s[0], r[0], fd, ad);
            from_off(s[0], r[0], ad);
          end

    // R8: flush never completes
    pulse_sleep(1'b1, 1'b0);
    n = 0;
    while (phase == 4'(PH_FLUSH) && n < 100) begin n++; tick(); end
    check("R8 flush window", n, TMO);
    check("R8 flush abort phase", int'(phase), int'(PH_IDLE));
    check("R8 flag", int'(timeout), 1);
    check("R8 flush released", int'(flush_req), 0);

    // R8: acknowledge never arrives
    pulse_sleep(1'b1, 1'b0);
    check("R8 flag cleared", int'(timeout), 0);
    flush_ok = 1'b1; tick(); flush_ok = 1'b0;
    n = 0;
    while (phase == 4'(PH_GATE_LOGIC) && n < 100) begin n++; tick(); end
    check("R8 ack window", n, TMO);
    check("R8 ack abort phase", int'(phase), int'(PH_IDLE));
    check("R8 pd released", int'(logic_pd), 0);
    check("R8 sram untouched", int'(sram_gate), 0);
    check("R8 flag ack", int'(timeout), 1);

    // R8: acknowledge never drops on wake (SRAM gated: one hold cycle first)
    to_off(1'b1, 1'b0, 1, 0);
    wake_cmd = 1'b1; tick(); wake_cmd = 1'b0;
    n = 0;
    while (phase == 4'(PH_UNGATE) && n < 100) begin n++; tick(); end
    check("R8 wake window", n, TMO + 1);
    check("R8 wake abort phase", int'(phase), int'(PH_IDLE));
    check("R8 wake outs", int'({logic_pd, sram_gate}), 0);
    check("R8 flag wake", int'(timeout), 1);
    pd_ack = 1'b0;
    tick();

    // Normal cycle after a timeout clears the flag
    to_off(1'b0, 1'b1, 0, 1);
    from_off(1'b0, 1'b1, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < WDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule